// File: doc/BRIEF.md
# Interrupt-Driven Single-Item Move Engine

This block services granted interrupt requests by copying one data item from one memory address to another, so the processor never runs a handler for routine data shuffling. It holds eight channels. Each channel has a 16-bit source pointer, a 16-bit destination pointer, an 8-bit remaining-move count, an item size of byte or word, and a pointer-step mode. An external arbiter decides which request wins and presents the winning channel number on a one-cycle service strobe. The engine then runs one read beat and one write beat on a shared memory master port with request/grant handshaking. It then steps the chosen pointer and updates the count.

When a channel's count runs out, the channel switches itself off and raises a one-cycle processor interrupt for that channel. From then on, further requests on that channel are passed to the processor as ordinary interrupts instead of moving data. A count of all ones keeps a channel running forever. Channels are set up through a simple write-only configuration port.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset, svcReady is 1, memReq, xferDone and cpuIrq are 0, and every channel is disabled.
- R2: A configuration write selects a field with cfgSel. Code 0 writes the source pointer and 1 writes the destination pointer. Code 2 writes the control word: bits 7:0 are the count, bit 8 selects word size (1 = word, 0 = byte), bits 10:9 are the step mode (01 = step source, 10 = step destination, 00 or 11 = no step), and bit 11 is the enable. Code 3 is ignored.
- R3: An svcReq accepted in idle on an enabled channel gives a read beat in the next cycle (memReq=1, memWe=0, memAddr=source). The read beat is held until memGnt is high, and memRdata is taken in that grant cycle. A write beat (memWe=1, memAddr=destination, memWdata=data) follows in the next cycle and is held until memGnt is high. svcReady is 0 from the read beat until the write grant.
- R4: xferDone is 1, with xferChan equal to the serviced channel, in exactly the cycle the write beat is granted, and is 0 otherwise.
- R5: A byte move drives memByte=1 and writes memRdata[7:0] zero-extended. A word move drives memByte=0, forces address bit 0 to 0 on both beats, and writes all 16 bits.
- R6: After a move, step mode 01 adds 1 (byte) or 2 (word) to the source pointer, mode 10 adds the same to the destination pointer, and modes 00 and 11 change neither. Pointers wrap at 16 bits.
- R7: Each move lowers a count that is not 0xFF by one, and a count of 0 stays 0. When the count after a move is 0, the channel is disabled and cpuIrq[channel] is 1 for exactly the cycle after the write grant. A move started with count 0 still takes place and ends the channel.
- R8: A count of 0xFF is never lowered and never ends the channel.
- R9: An svcReq in idle for a disabled channel produces no bus beat, and cpuIrq[channel] is 1 for exactly the next cycle.
- R10: An svcReq while svcReady is 0 is ignored: it starts no move and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | 3 | Channel written |
| cfgSel | input | 2 | Field select (R2) |
| cfgData | input | 16 | Configuration data |
| svcReq | input | 1 | Granted service request strobe |
| svcChan | input | 3 | Channel of the service request |
| svcReady | output | 1 | Engine idle and able to accept a request |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 for write beat, 0 for read beat |
| memByte | output | 1 | Beat is a byte access |
| memAddr | output | 16 | Beat address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid in the grant cycle |
| memGnt | input | 1 | Memory grant for the current beat |
| xferDone | output | 1 | Move completion pulse with the write grant |
| xferChan | output | 3 | Channel of the current move |
| cpuIrq | output | 8 | Per-channel processor interrupt pulses |

## Verification
The assertions assume that memGnt is raised only while memReq is high and that memRdata is valid in the same cycle as a read grant. They also assume that no configuration write targets the channel that is moving. The stimulus raises the grant only after it has seen the beat it belongs to, and returns read data combinationally from the address. It reconfigures channels only while the engine is idle, and it places a busy-time request only during a read beat that is held for at least one cycle.

// File: rtl/ixe_pkg.sv
package ixe_pkg;
  parameter int NUM_CHAN = 8;
  parameter int ADDR_W   = 16;
  parameter int DATA_W   = 16;
  parameter int CNT_W    = 8;
  localparam int CHAN_W  = $clog2(NUM_CHAN);
  localparam logic [CNT_W-1:0] CNT_LOOP = {CNT_W{1'b1}};

  // control word field positions
  localparam int CTRL_WORD_BIT = CNT_W;
  localparam int CTRL_STEP_LO  = CNT_W + 1;
  localparam int CTRL_EN_BIT   = CNT_W + 3;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfgSel_e;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_SRC   = 2'd1,
    STEP_DST   = 2'd2,
    STEP_NONE2 = 2'd3
  } stepMode_e;

  typedef struct packed {
    logic              capture;  // read beat granted
    logic              commit;   // write beat granted
    logic              bounce;   // request on disabled channel
    logic              wrPhase;  // address mux select
    logic [CHAN_W-1:0] chan;     // channel addressed
  } ctlStrb_t;
endpackage

// File: rtl/ixe_control.sv
module ixe_control
  import ixe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                svcReq,
  input  logic [CHAN_W-1:0]   svcChan,
  input  logic [NUM_CHAN-1:0] chanEn,
  input  logic                memGnt,
  output logic                svcReady,
  output logic                memReq,
  output logic                memWe,
  output logic                xferDone,
  output logic [CHAN_W-1:0]   xferChan,
  output ctlStrb_t            strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;
  state_e            state;
  logic [CHAN_W-1:0] activeChan;
  logic              accept;

  assign accept = (state == ST_IDLE) && svcReq && chanEn[svcChan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      activeChan <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          activeChan <= svcChan;
          state      <= ST_READ;
        end
        ST_READ:  if (memGnt) state <= ST_WRITE;
        ST_WRITE: if (memGnt) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    svcReady     = (state == ST_IDLE);
    memReq       = (state != ST_IDLE);
    memWe        = (state == ST_WRITE);
    xferDone     = (state == ST_WRITE) && memGnt;
    xferChan     = activeChan;
    strb.chan    = (state == ST_IDLE) ? svcChan : activeChan;
    strb.capture = (state == ST_READ) && memGnt;
    strb.commit  = (state == ST_WRITE) && memGnt;
    strb.bounce  = (state == ST_IDLE) && svcReq && !chanEn[svcChan];
    strb.wrPhase = (state == ST_WRITE);
  end
endmodule

// File: rtl/ixe_datapath.sv
module ixe_datapath
  import ixe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic                cfgWe,
  input  logic [CHAN_W-1:0]   cfgChan,
  input  logic [1:0]          cfgSel,
  input  logic [DATA_W-1:0]   cfgData,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [NUM_CHAN-1:0] chanEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memByte,
  output logic [NUM_CHAN-1:0] cpuIrq
);
  logic [ADDR_W-1:0] srcArr  [NUM_CHAN];
  logic [ADDR_W-1:0] dstArr  [NUM_CHAN];
  logic [CNT_W-1:0]  cntNext [NUM_CHAN];
  logic [NUM_CHAN-1:0] wordArr;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_ch
    logic [ADDR_W-1:0] srcPtr, dstPtr, stepAmt;
    logic [CNT_W-1:0]  cnt;
    logic              isWord, enR;
    stepMode_e         mode;
    logic              hit, cfgHit;

    assign hit     = strb.commit && (strb.chan == CHAN_W'(g));
    assign cfgHit  = cfgWe && (cfgChan == CHAN_W'(g));
    assign stepAmt = isWord ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
      if (cnt == CNT_LOOP)  cntNext[g] = CNT_LOOP;
      else if (cnt == '0)   cntNext[g] = '0;
      else                  cntNext[g] = cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcPtr <= '0;
        dstPtr <= '0;
        cnt    <= '0;
        isWord <= 1'b0;
        enR    <= 1'b0;
        mode   <= STEP_NONE;
      end else if (hit) begin
        if (mode == STEP_SRC) srcPtr <= srcPtr + stepAmt;
        if (mode == STEP_DST) dstPtr <= dstPtr + stepAmt;
        cnt <= cntNext[g];
        if (cntNext[g] == '0) enR <= 1'b0;
      end else if (cfgHit) begin
        unique case (cfgSel_e'(cfgSel))
          SEL_SRC:  srcPtr <= cfgData[ADDR_W-1:0];
          SEL_DST:  dstPtr <= cfgData[ADDR_W-1:0];
          SEL_CTRL: begin
            cnt    <= cfgData[CNT_W-1:0];
            isWord <= cfgData[CTRL_WORD_BIT];
            mode   <= stepMode_e'(cfgData[CTRL_STEP_LO +: 2]);
            enR    <= cfgData[CTRL_EN_BIT];
          end
          default: ;
        endcase
      end
    end

    assign srcArr[g]  = srcPtr;
    assign dstArr[g]  = dstPtr;
    assign wordArr[g] = isWord;
    assign chanEn[g]  = enR;
  end

  logic              curWord;
  logic [ADDR_W-1:0] rawAddr;
  logic [DATA_W-1:0] dataReg;
  logic              finish;

  assign curWord  = wordArr[strb.chan];
  assign rawAddr  = strb.wrPhase ? dstArr[strb.chan] : srcArr[strb.chan];
  assign memAddr  = curWord ? {rawAddr[ADDR_W-1:1], 1'b0} : rawAddr;
  assign memByte  = !curWord;
  assign memWdata = dataReg;
  assign finish   = strb.commit && (cntNext[strb.chan] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      cpuIrq  <= '0;
    end else begin
      if (strb.capture)
        dataReg <= curWord ? memRdata : {{(DATA_W-8){1'b0}}, memRdata[7:0]};
      cpuIrq <= '0;
      if (strb.bounce || finish) cpuIrq[strb.chan] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
  import ixe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CHAN_W-1:0]   cfgChan,
  input  logic [1:0]          cfgSel,
  input  logic [DATA_W-1:0]   cfgData,
  input  logic                svcReq,
  input  logic [CHAN_W-1:0]   svcChan,
  output logic                svcReady,
  output logic                memReq,
  output logic                memWe,
  output logic                memByte,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memGnt,
  output logic                xferDone,
  output logic [CHAN_W-1:0]   xferChan,
  output logic [NUM_CHAN-1:0] cpuIrq
);
  ctlStrb_t            strb;
  logic [NUM_CHAN-1:0] chanEn;

  ixe_control u_ctl (
    .clk, .rstN, .svcReq, .svcChan, .chanEn, .memGnt,
    .svcReady, .memReq, .memWe, .xferDone, .xferChan, .strb
  );

  ixe_datapath u_dp (
    .clk, .rstN, .strb, .cfgWe, .cfgChan, .cfgSel, .cfgData,
    .memRdata, .chanEn, .memAddr, .memWdata, .memByte, .cpuIrq
  );
endmodule

// File: rtl/ixe_chk.sv
module ixe_chk
  import ixe_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                svcReady,
  input logic                memReq,
  input logic                memWe,
  input logic                memByte,
  input logic [ADDR_W-1:0]   memAddr,
  input logic                memGnt,
  input logic                xferDone,
  input logic [NUM_CHAN-1:0] cpuIrq
);
  // R3
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe));
  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memGnt |=> memReq && memWe);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    svcReady |-> !memReq);
  // R4
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> memReq && memWe && memGnt);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);
  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memByte |-> !memAddr[0]);
  // R7
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cpuIrq));
endmodule

bind irq_xfer_engine ixe_chk u_chk (
  .clk(clk), .rstN(rstN), .svcReady(svcReady), .memReq(memReq),
  .memWe(memWe), .memByte(memByte), .memAddr(memAddr), .memGnt(memGnt),
  .xferDone(xferDone), .cpuIrq(cpuIrq)
);

// File: tb/tb_irq_xfer_engine.sv
module tb_irq_xfer_engine;
  logic clk = 0, rstN = 0;
  logic cfgWe = 0; logic [2:0] cfgChan = 0; logic [1:0] cfgSel = 0; logic [15:0] cfgData = 0;
  logic svcReq = 0; logic [2:0] svcChan = 0;
  logic svcReady, memReq, memWe, memByte, memGnt = 0, xferDone;
  logic [15:0] memAddr, memWdata, memRdata;
  logic [2:0] xferChan; logic [7:0] cpuIrq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;
  assign memRdata = memAddr ^ 16'hA5C3;

  irq_xfer_engine dut (.*);

  // bench model of channel state
  logic [15:0] mSrc[8], mDst[8]; logic [7:0] mCnt[8];
  logic mWord[8], mEn[8]; logic [1:0] mMode[8];

  typedef struct packed {
    logic [2:0] ch; logic [15:0] src; logic [15:0] dst; logic [15:0] ctrl;
    logic [3:0] moves; logic [2:0] dly;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{3'd0, 16'h1000, 16'h2000, 16'h0A03, 4'd3, 3'd0},
    '{3'd1, 16'h3001, 16'h4003, 16'h0D02, 4'd2, 3'd1},
    '{3'd2, 16'h5555, 16'h6666, 16'h0905, 4'd2, 3'd2},
    '{3'd7, 16'hFFFF, 16'h0010, 16'h0AFF, 4'd3, 3'd0},
    '{3'd5, 16'h0100, 16'h0200, 16'h0F04, 4'd2, 3'd1},
    '{3'd3, 16'h0020, 16'h0030, 16'h0801, 4'd1, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int ch, input int sel, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1; cfgChan = 3'(ch); cfgSel = 2'(sel); cfgData = d;
    @(negedge clk);
    cfgWe = 0;
    case (sel)
      0: mSrc[ch] = d;
      1: mDst[ch] = d;
      2: begin mCnt[ch] = d[7:0]; mWord[ch] = d[8]; mMode[ch] = d[10:9]; mEn[ch] = d[11]; end
      default: ;
    endcase
  endtask

  task automatic runMove(input int ch, input int dly, input int intrude);
    logic [15:0] sA, dA, dat, step; logic [7:0] nc; bit fin;
    sA = mWord[ch] ? {mSrc[ch][15:1], 1'b0} : mSrc[ch];
    dA = mWord[ch] ? {mDst[ch][15:1], 1'b0} : mDst[ch];
    dat = mWord[ch] ? (sA ^ 16'hA5C3) : {8'h00, sA[7:0] ^ 8'hC3};
    nc = (mCnt[ch] == 8'hFF) ? 8'hFF : (mCnt[ch] == 0 ? 8'h00 : mCnt[ch] - 8'd1);
    fin = (nc == 0);
    @(negedge clk); svcChan = 3'(ch); svcReq = 1;
    @(negedge clk); svcReq = 0; #1;
    chk(memReq && !memWe && !svcReady, "R3 read beat", {memReq, memWe}, 2);
    chk(memAddr == sA, "R3/R5 read addr", memAddr, sA);
    chk(memByte == !mWord[ch], "R5 size", memByte, !mWord[ch]);
    if (intrude >= 0) begin
      svcChan = 3'(intrude); svcReq = 1;
      @(negedge clk); svcReq = 0;
    end
    repeat (dly) @(negedge clk);
    memGnt = 1;
    @(negedge clk); memGnt = 0; #1;
    chk(memReq && memWe, "R3 write beat", {memReq, memWe}, 3);
    chk(memAddr == dA, "R3/R5 write addr", memAddr, dA);
    chk(memWdata == dat, "R5 write data", memWdata, dat);
    chk(!xferDone, "R4 no done before grant", xferDone, 0);
    repeat (dly) @(negedge clk);
    memGnt = 1; #1;
    chk(xferDone && xferChan == 3'(ch), "R4 done", {xferDone, xferChan}, {1'b1, 3'(ch)});
    @(negedge clk); memGnt = 0; #1;
    chk(svcReady && !memReq, "R3 back idle", {svcReady, memReq}, 2);
    chk(cpuIrq == (fin ? 8'(1 << ch) : 8'h00), "R7/R8 end irq", cpuIrq, fin ? (1 << ch) : 0);
    step = mWord[ch] ? 16'd2 : 16'd1;
    if (mMode[ch] == 2'b01) mSrc[ch] = mSrc[ch] + step;
    if (mMode[ch] == 2'b10) mDst[ch] = mDst[ch] + step;
    mCnt[ch] = nc;
    if (fin) mEn[ch] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mSrc[i] = 0; mDst[i] = 0; mCnt[i] = 0; mWord[i] = 0; mEn[i] = 0; mMode[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(svcReady && !memReq && !xferDone && cpuIrq == 0, "R1 reset outputs",
        {svcReady, memReq, xferDone, cpuIrq}, 11'h400);
    rstN = 1;
    // R1: channel 6 disabled after reset, so its request bounces
    @(negedge clk); svcChan = 3'd6; svcReq = 1;
    @(negedge clk); svcReq = 0; #1;
    chk(!memReq && cpuIrq == 8'h40, "R1/R9 reset channel disabled", cpuIrq, 8'h40);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    foreach (VECS[v]) begin
      cfgWrite(VECS[v].ch, 0, VECS[v].src);
      cfgWrite(VECS[v].ch, 1, VECS[v].dst);
      cfgWrite(VECS[v].ch, 3, 16'hDEAD);  // R2 code 3 ignored
      cfgWrite(VECS[v].ch, 2, VECS[v].ctrl);
      for (int m = 0; m < int'(VECS[v].moves); m++)
        runMove(VECS[v].ch, int'(VECS[v].dly), -1);
    end

    // R9: channel 0 ended by its count, request now bounces
    @(negedge clk); svcChan = 3'd0; svcReq = 1;
    @(negedge clk); svcReq = 0; #1;
    chk(!memReq && svcReady, "R9 no beat", memReq, 0);
    chk(cpuIrq == 8'h01, "R9 irq pulse", cpuIrq, 8'h01);
    @(negedge clk); #1;
    chk(cpuIrq == 8'h00, "R9 pulse one cycle", cpuIrq, 0);

    // R7: count 0 on enable still moves once and ends
    cfgWrite(4, 0, 16'h0700);
    cfgWrite(4, 1, 16'h0800);
    cfgWrite(4, 2, 16'h0A00);
    runMove(4, 0, -1);
    chk(mEn[4] == 0, "R7 count-zero ends", mEn[4], 0);

    // R10: request during read beat ignored; ch2 (count 3 left) serviced, ch7 intrudes
    runMove(2, 1, 7);
    @(negedge clk); #1;
    chk(!memReq && svcReady, "R10 no extra move", memReq, 0);
    // ch7 pointer unchanged: next move reads the model's address
    runMove(7, 0, -1);

    // R8: ch7 still enabled after many moves
    runMove(7, 1, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule